// File: doc/BRIEF.md
# Keyed Fractional Clock Divider

This block generates a slow bit clock from one of up to eight source tick streams. Every source is presented as a one-cycle tick in the common system clock domain, and index 0 is tied to ground. The divider counts ticks of the chosen source. It produces two outputs. The first is a registered level, `clk_out`. The second is a one-cycle enable, `clk_ce`, that marks each rising edge of that level. Downstream logic uses `clk_ce` as a clock enable and never as a real clock.

Software reaches the block through two 32-bit registers: a control word and a divisor. A write takes effect only when the top byte of the data matches a fixed key, so a stray write leaves both registers untouched. The divisor has a 12-bit integer part and a 12-bit fraction counted in 1/4096 steps. When shaping is on, a first-order accumulator stretches individual output periods by one tick, so the long-run average period equals the programmed fractional ratio.

Clearing enable lets the current output period run to its end before busy drops. Setting kill forces the output and busy low at once. Source, divisor and shaping settings are captured only while busy is low. Values written while busy is high are held until the divider has stopped.

Top module: `keyed_frac_clkdiv`

## Requirements
- R1: A write takes effect only if `wr_data[31:24]` equals 8'h5A. Any other key leaves both registers unchanged. Bits 31:24 always read back as zero.
- R2: Control word layout: [3:0] source, [4] enable, [5] kill, [7] busy (read-only), [10:9] stage count. Divisor word layout: [23:12] integer, [11:0] fraction. All other bits read as zero. `rd_addr`/`wr_addr` 0 selects control and 1 selects divisor.
- R3: A source value of 0, or of 8 to 15, produces no ticks, so the divider never starts. A value n from 1 to 7 counts the ticks of `src_tick[n]`.
- R4: With stage count 0, every output period is the integer divisor in source ticks, and the fraction is ignored. An integer below 2 is treated as 2.
- R5: With a nonzero stage count, the fraction is added to an accumulator that starts at zero once per period. A carry lengthens that period to integer+1. The first 8 periods after a start therefore total 8*integer + floor(8*fraction/4096) ticks.
- R6: `clk_out` is high for floor(P/2) ticks of each P-tick period. `clk_ce` is high for exactly the system cycles in which `clk_out` rises.
- R7: Busy rises together with the first output edge after enable. Busy stays high whenever the output is running.
- R8: Clearing enable lets the running period finish. Busy then falls at that period's end, within one period, and no further `clk_ce` appears.
- R9: Once kill is written, busy and `clk_out` are low two system cycles after the write cycle. No start happens while kill is set.
- R10: Divisor, stage and source changes written while busy take effect only after busy falls. The readback shows the new value at once.
- R11: After reset both registers read as zero, and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every source tick is sampled here |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write select: 0 control, 1 divisor |
| wr_data | input | 32 | Write data; top byte carries the key |
| rd_addr | input | 1 | Read select: 0 control, 1 divisor |
| rd_data | output | 32 | Combinational readback |
| src_tick | input | 8 | Per-source tick pulses; index 0 is ignored (ground) |
| clk_ce | output | 1 | One-cycle pulse at each rising edge of the output |
| clk_out | output | 1 | Divided output level |

## Verification
A corrupted accumulator or period register shows up as a wrong spacing between `clk_ce` pulses within a few output periods. For that reason the bench measures the summed spacing over eight periods, where a single missing or extra carry moves the total by one cycle. A busy flag stuck in the wrong state shows within one period as well: a stop never completes, configuration changes leak into a running clock, or a second start appears on the readback. Key or field-decode faults show on the very next readback of `rd_data`.

// File: rtl/keyed_frac_clkdiv.sv
module keyed_frac_clkdiv #(
  parameter logic [7:0] KEY  = 8'h5A,
  parameter int         NSRC = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_addr,
  input  logic [31:0] wr_data,
  input  logic        rd_addr,
  output logic [31:0] rd_data,
  input  logic [NSRC-1:0] src_tick,
  output logic        clk_ce,
  output logic        clk_out
);
  localparam int SELW = $clog2(NSRC);

  logic [3:0]  p_src, a_src, e_src;
  logic [1:0]  p_stg, a_stg, e_stg;
  logic [11:0] p_int, a_int, e_int, p_frac, a_frac, e_frac;
  logic        enab, kill, busy;
  logic [11:0] acc;
  logic [12:0] cnt, per;

  wire key_ok = wr_en && (wr_data[31:24] == KEY);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      p_src <= '0; p_stg <= '0; enab <= 1'b0; kill <= 1'b0;
      p_int <= '0; p_frac <= '0;
    end else if (key_ok) begin
      if (!wr_addr) begin
        p_src <= wr_data[3:0]; enab <= wr_data[4];
        kill  <= wr_data[5];   p_stg <= wr_data[10:9];
      end else begin
        p_int <= wr_data[23:12]; p_frac <= wr_data[11:0];
      end
    end

  assign rd_data = rd_addr ? {8'h00, p_int, p_frac}
                           : {21'd0, p_stg, 1'b0, busy, 1'b0, kill, enab, p_src};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      a_src <= '0; a_stg <= '0; a_int <= '0; a_frac <= '0;
    end else if (!busy) begin
      a_src <= p_src; a_stg <= p_stg; a_int <= p_int; a_frac <= p_frac;
    end

  assign e_src  = busy ? a_src  : p_src;
  assign e_stg  = busy ? a_stg  : p_stg;
  assign e_int  = busy ? a_int  : p_int;
  assign e_frac = busy ? a_frac : p_frac;

  wire        tick    = (e_src != 4'd0) && (e_src < 4'(NSRC)) && src_tick[e_src[SELW-1:0]];
  wire [11:0] int_c   = (e_int < 12'd2) ? 12'd2 : e_int;
  wire [12:0] sum     = {1'b0, busy ? acc : 12'd0} + {1'b0, e_frac};
  wire        frac_on = (e_stg != 2'd0);
  wire        carry   = frac_on && sum[12];
  wire [12:0] nxt_per = {1'b0, int_c} + {12'd0, carry};
  wire        bound   = busy && (cnt == per - 13'd1);
  wire [12:0] cnt_inc = cnt + 13'd1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0; clk_out <= 1'b0; clk_ce <= 1'b0;
      cnt <= '0; per <= 13'd2; acc <= '0;
    end else begin
      clk_ce <= 1'b0;
      if (kill) begin
        busy <= 1'b0; clk_out <= 1'b0; cnt <= '0; acc <= '0;
      end else if (tick) begin
        if (busy ? bound : enab) begin
          if (enab) begin
            busy <= 1'b1; clk_out <= 1'b1; clk_ce <= 1'b1;
            cnt <= '0; per <= nxt_per;
            acc <= frac_on ? sum[11:0] : 12'd0;
          end else begin
            busy <= 1'b0; clk_out <= 1'b0; cnt <= '0; acc <= '0;
          end
        end else if (busy) begin
          cnt <= cnt_inc;
          if (cnt_inc == (per >> 1)) clk_out <= 1'b0;
        end
      end
    end

  p_key_guard_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[31:24] != KEY) |=> $stable({p_src, enab, kill, p_stg, p_int, p_frac}));
  p_ce_at_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clk_ce == $rose(clk_out));
  p_out_needs_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clk_out |-> busy);
  p_kill_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (!busy && !clk_out));
  p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable({a_src, a_stg, a_int, a_frac}));
  p_cnt_in_period_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt < per));
endmodule

// File: tb/sim_keyed_frac_clkdiv.sv
module sim_keyed_frac_clkdiv;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 9;
  localparam logic [25:0] VEC [NV] = '{
    {12'd4, 12'd0,    2'd0},
    {12'd5, 12'd0,    2'd0},
    {12'd0, 12'd0,    2'd0},
    {12'd1, 12'd0,    2'd0},
    {12'd4, 12'd2048, 2'd1},
    {12'd3, 12'd1024, 2'd1},
    {12'd6, 12'd2048, 2'd0},
    {12'd2, 12'd4095, 2'd1},
    {12'd7, 12'd512,  2'd2}
  };

  logic clk = 0, rst_n = 0, wr_en = 0, wr_addr = 0, rd_addr = 0, alt = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic [7:0] src_tick;
  logic clk_ce, clk_out;
  int n_checks = 0, n_fail = 0;

  assign src_tick = {1'b1, alt, 1'b1, alt, 1'b1, alt, 1'b1, alt};

  keyed_frac_clkdiv u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .src_tick(src_tick),
    .clk_ce(clk_ce), .clk_out(clk_out));

  always #(CLK_PERIOD/2) clk = ~clk;
  initial forever @(negedge clk) alt <= ~alt;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_ctl(input logic [3:0] s, input logic en,
                                         input logic k, input logic [1:0] st);
    return {8'h5A, 13'd0, st, 3'b000, k, en, s};
  endfunction
  function automatic logic [31:0] mk_div(input logic [11:0] i, input logic [11:0] f);
    return {8'h5A, i, f};
  endfunction

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data; rd_addr = 0;
  endtask

  task automatic stop_wait;
    int g = 0;
    wr(0, mk_ctl(4'd1, 1'b0, 1'b0, 2'd0));
    while (rd_data[7] && g < 10000) begin @(negedge clk); g++; end
  endtask

  task automatic run_periods(input int nper, output int total, output int hi);
    int g = 0, k = 0;
    total = 0; hi = 0;
    while (!clk_ce && g < 20000) begin @(negedge clk); g++; end
    if (!clk_ce) return;
    hi = clk_out ? 1 : 0;
    while (k < nper && g < 20000) begin
      @(negedge clk); g++; total++;
      if (clk_ce) k++;
      else if (k == 0 && clk_out) hi++;
    end
  endtask

  task automatic count_ce(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (clk_ce) c++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int tot, hi, c, g;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    rd(0, d); check(d == 0, "R11 ctl reset", d, 0);
    rd(1, d); check(d == 0, "R11 div reset", d, 0);
    check(clk_out == 0, "R11 clk_out reset", clk_out, 0);
    check(clk_ce == 0, "R11 clk_ce reset", clk_ce, 0);

    // R2 field layout and read-only busy
    wr(0, 32'h5A0004C3);
    rd(0, d); check(d == 32'h00000403, "R2 ctl layout", d, 32'h403);
    wr(1, mk_div(12'hABC, 12'h123));
    rd(1, d); check(d == 32'h00ABC123, "R2 div layout", d, 32'hABC123);

    // R1 wrong key ignored
    wr(0, {8'h5B, 24'h000011});
    rd(0, d); check(d == 32'h00000403, "R1 bad key ctl", d, 32'h403);
    count_ce(30, c); check(c == 0, "R1 bad key no start", c, 0);
    wr(1, {8'h00, 24'h004000});
    rd(1, d); check(d == 32'h00ABC123, "R1 bad key div", d, 32'hABC123);
    check(d[31:24] == 0, "R1 key reads zero", d[31:24], 0);

    // R4 R5 R6 R7 table
    for (int v = 0; v < NV; v++) begin
      logic [11:0] vi, vf; logic [1:0] vs; int ic, et;
      {vi, vf, vs} = VEC[v];
      ic = (vi < 2) ? 2 : int'(vi);
      et = 8 * ic + ((vs != 0) ? (8 * int'(vf)) / 4096 : 0);
      wr(1, mk_div(vi, vf));
      wr(0, mk_ctl(4'd1, 1'b1, 1'b0, vs));
      run_periods(8, tot, hi);
      check(tot == et, vs == 0 ? "R4 integer period total" : "R5 fractional period total", tot, et);
      check(hi == ic / 2, "R6 high time", hi, ic / 2);
      rd(0, d); check(d[7] == 1, "R7 busy while running", d[7], 1);
      stop_wait();
    end

    // R3 source selection
    wr(1, mk_div(12'd4, 12'd0));
    wr(0, mk_ctl(4'd2, 1'b1, 1'b0, 2'd0));
    run_periods(4, tot, hi);
    check(tot == 32, "R3 half-rate source", tot, 32);
    wr(0, mk_ctl(4'd2, 1'b0, 1'b0, 2'd0));
    g = 0; while (rd_data[7] && g < 1000) begin @(negedge clk); g++; end
    wr(0, mk_ctl(4'd0, 1'b1, 1'b0, 2'd0));
    count_ce(40, c); check(c == 0, "R3 ground source no ce", c, 0);
    rd(0, d); check(d[7] == 0, "R3 ground source no busy", d[7], 0);
    wr(0, mk_ctl(4'd9, 1'b1, 1'b0, 2'd0));
    count_ce(40, c); check(c == 0, "R3 out-of-range source", c, 0);
    wr(0, mk_ctl(4'd9, 1'b0, 1'b0, 2'd0));

    // R10 deferred divisor change
    wr(0, mk_ctl(4'd1, 1'b1, 1'b0, 2'd0));
    run_periods(2, tot, hi);
    wr(1, mk_div(12'd8, 12'd0));
    rd(1, d); check(d == 32'h00008000, "R10 readback immediate", d, 32'h8000);
    run_periods(4, tot, hi);
    check(tot == 16, "R10 old divisor kept while busy", tot, 16);
    stop_wait();
    wr(0, mk_ctl(4'd1, 1'b1, 1'b0, 2'd0));
    run_periods(4, tot, hi);
    check(tot == 32, "R10 new divisor after stop", tot, 32);
    stop_wait();

    // R8 graceful stop
    wr(1, mk_div(12'd10, 12'd0));
    wr(0, mk_ctl(4'd1, 1'b1, 1'b0, 2'd0));
    g = 0; while (!clk_ce && g < 1000) begin @(negedge clk); g++; end
    wr(0, mk_ctl(4'd1, 1'b0, 1'b0, 2'd0));
    rd(0, d); check(d[7] == 1, "R8 busy held after enable cleared", d[7], 1);
    c = 0; g = 0;
    while (rd_data[7] && g < 40) begin @(negedge clk); g++; if (clk_ce) c++; end
    check(g <= 10, "R8 busy falls within a period", g, 10);
    check(c == 0, "R8 no edge while stopping", c, 0);
    count_ce(30, tot); check(tot == 0, "R8 stays stopped", tot, 0);

    // R9 kill
    wr(0, mk_ctl(4'd1, 1'b1, 1'b0, 2'd0));
    g = 0; while (!clk_ce && g < 1000) begin @(negedge clk); g++; end
    wr(0, mk_ctl(4'd1, 1'b1, 1'b1, 2'd0));
    @(negedge clk);
    rd(0, d); check(d[7] == 0, "R9 busy cleared by kill", d[7], 0);
    check(clk_out == 0, "R9 output forced low", clk_out, 0);
    count_ce(40, c); check(c == 0, "R9 no start while kill", c, 0);
    wr(0, mk_ctl(4'd1, 1'b0, 1'b0, 2'd0));

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule